// File: doc/BRIEF.md
# Pi/4 DQPSK baseband symbol mapper

This block turns a serial stream of transmit bits into 10-bit two's-complement I and Q sample words for a quadrature modulator. Bits arrive one at a time with a qualifier. Every two bits form a dibit: the first bit is X and the second is Y. The dibit selects a phase step of ±π/4 or ±3π/4. The step is added to a 3-bit phase accumulator held in units of π/4. The new phase then selects a point on an eight-point circle. Because the mapping is differential, each dibit moves the previous point; it does not pick an absolute one.

Samples are produced on a fixed sample tick, one every 16 clocks. A burst request input starts and ends transmission. When a burst opens, the amplitude ramps up linearly over eight samples. When it closes, the amplitude ramps down over eight samples, and the phase stays frozen during both ramps. A bypass input replaces the mapper output with externally supplied I/Q words. These words are clamped to the same reduced code range that protects the calibration headroom.

Top module: `dqpsk_mapper`

## Requirements
- R1: A dibit {X,Y} (X is the first bit received) advances the phase index modulo 8 by: 00 → +1, 01 → +3, 11 → +5 (−3), 10 → +7 (−1).
- R2: At full amplitude, phase index k gives (I,Q) = 0:(400,0), 1:(283,283), 2:(0,400), 3:(−283,283), 4:(−400,0), 5:(−283,−283), 6:(0,−400), 7:(283,−283), as 10-bit two's complement.
- R3: Every output word lies within −450..+450.
- R4: A burst starts on a sample tick in idle with burst_req high. The phase resets to index 0 and eight ramp samples follow at levels 0,1,…,7. Each is floor(p·level/8) of the current point p. Full-amplitude samples follow after that.
- R5: A sample tick that sees burst_req low while running starts the ramp-down. It gives eight samples at levels 7,6,…,0 of the current point. A dibit pending at that tick is dropped. The block then returns to idle with zero outputs and no strobes.
- R6: The phase does not change during either ramp. Bits received outside the running state are discarded.
- R7: A running sample tick with no complete dibit repeats the previous point at full amplitude.
- R8: smp_valid is high for exactly one clock per sample, and samples are spaced 16 clocks apart.
- R9: With bypass high, each sample tick outputs ext_i/ext_q clamped to ±450 with smp_valid, and the burst logic is held idle.
- R10: After reset, i_out and q_out are 0 and smp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Pass external words instead of mapped points |
| burst_req | input | 1 | High to open and hold a burst, low to close it |
| bit_valid | input | 1 | Qualifies bit_data for one clock |
| bit_data | input | 1 | Serial transmit bit, X first then Y |
| ext_i | input | 10 | External I word (two's complement), bypass mode |
| ext_q | input | 10 | External Q word (two's complement), bypass mode |
| i_out | output | 10 | I sample word |
| q_out | output | 10 | Q sample word |
| smp_valid | output | 1 | One-clock strobe with each new sample |

## Verification
The running state is fed a dibit sequence that uses all four codes and wraps the phase past index 7. Only a correct step table and modulo arithmetic reproduce the expected points. Bits sent during a ramp, and a dibit sent on the ramp-down tick, show whether the phase freezes as it should. A second burst opened from a non-zero phase shows whether the phase resets to index 0. The ramp-down runs from a diagonal point with negative components, which tells flooring apart from truncation toward zero. Bypass words at, inside and beyond ±450 test the clamp, and the gap between strobes tests the sample spacing.

// File: rtl/dqm_pkg.sv
package dqm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_UP, ST_RUN, ST_DN} burst_st_t;

  // {X,Y} -> phase step in units of pi/4
  function automatic logic [2:0] dibit_step(input logic [1:0] d);
    case (d)
      2'b00:   return 3'd1;
      2'b01:   return 3'd3;
      2'b11:   return 3'd5;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/dqm_tick.sv
module dqm_tick #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cnt == CW'(DIV - 1)) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/dqm_dibit.sv
module dqm_dibit (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       bit_valid,
  input  logic       bit_data,
  input  logic       take,
  output logic       pend,
  output logic [1:0] dibit
);
  logic half;
  logic xbit;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      half  <= 1'b0;
      xbit  <= 1'b0;
      pend  <= 1'b0;
      dibit <= 2'b00;
    end else begin
      if (take) pend <= 1'b0;
      if (bit_valid) begin
        if (!half) begin
          xbit <= bit_data;
          half <= 1'b1;
        end else begin
          dibit <= {xbit, bit_data};
          pend  <= 1'b1;
          half  <= 1'b0;
        end
      end
    end
  end

  // R6: bits seen outside the running state leave nothing behind
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!pend && !half));
endmodule

// File: rtl/dqm_point.sv
module dqm_point #(
  parameter int W        = 10,
  parameter int AXIS     = 400,
  parameter int DIAG     = 283,
  parameter int RAMP_LEN = 8,
  localparam int LVW     = $clog2(RAMP_LEN) + 1
) (
  input  logic [2:0]            idx,
  input  logic [LVW-1:0]        lvl,
  output logic signed [W-1:0]   pi,
  output logic signed [W-1:0]   pq
);
  localparam int SH = $clog2(RAMP_LEN);
  localparam int PW = W + LVW + 1;
  localparam logic signed [W-1:0] AX = W'(AXIS);
  localparam logic signed [W-1:0] DG = W'(DIAG);

  logic signed [W-1:0]  bi, bq;
  logic signed [PW-1:0] prod_i, prod_q, lv_s;

  always_comb begin
    case (idx)
      3'd0: begin bi = AX;     bq = '0;     end
      3'd1: begin bi = DG;     bq = DG;     end
      3'd2: begin bi = '0;     bq = AX;     end
      3'd3: begin bi = -DG;    bq = DG;     end
      3'd4: begin bi = -AX;    bq = '0;     end
      3'd5: begin bi = -DG;    bq = -DG;    end
      3'd6: begin bi = '0;     bq = -AX;    end
      default: begin bi = DG;  bq = -DG;    end
    endcase
  end

  assign lv_s   = $signed({{(W+1){1'b0}}, lvl});
  assign prod_i = $signed({{(LVW+1){bi[W-1]}}, bi}) * lv_s;
  assign prod_q = $signed({{(LVW+1){bq[W-1]}}, bq}) * lv_s;
  assign pi     = W'(prod_i >>> SH);
  assign pq     = W'(prod_q >>> SH);
endmodule

// File: rtl/dqpsk_mapper.sv
module dqpsk_mapper #(
  parameter int W        = 10,
  parameter int DIV      = 16,
  parameter int RAMP_LEN = 8,
  parameter int AXIS     = 400,
  parameter int DIAG     = 283,
  parameter int LIMIT    = 450
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bypass,
  input  logic                burst_req,
  input  logic                bit_valid,
  input  logic                bit_data,
  input  logic signed [W-1:0] ext_i,
  input  logic signed [W-1:0] ext_q,
  output logic signed [W-1:0] i_out,
  output logic signed [W-1:0] q_out,
  output logic                smp_valid
);
  import dqm_pkg::*;

  localparam int LVW = $clog2(RAMP_LEN) + 1;
  localparam logic signed [W-1:0] LIM_P = W'(LIMIT);
  localparam logic signed [W-1:0] LIM_N = -LIM_P;

  burst_st_t      st;
  logic [2:0]     phase, phase_sel;
  logic [LVW-1:0] level, level_sel;
  logic           tick, pend, take, flush;
  logic [1:0]     dibit;
  logic signed [W-1:0] li, lq;

  function automatic logic signed [W-1:0] clamp(input logic signed [W-1:0] v);
    if (v > LIM_P)      return LIM_P;
    else if (v < LIM_N) return LIM_N;
    else                return v;
  endfunction

  dqm_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  assign flush = bypass || (st != ST_RUN);
  assign take  = tick && !bypass && (st == ST_RUN) && burst_req && pend;

  dqm_dibit u_dibit (
    .clk(clk), .rst(rst), .flush(flush), .bit_valid(bit_valid),
    .bit_data(bit_data), .take(take), .pend(pend), .dibit(dibit)
  );

  assign phase_sel = take ? (phase + dibit_step(dibit)) : phase;
  assign level_sel = (st == ST_RUN && !burst_req) ? LVW'(RAMP_LEN - 1) : level;

  dqm_point #(.W(W), .AXIS(AXIS), .DIAG(DIAG), .RAMP_LEN(RAMP_LEN)) u_point (
    .idx(phase_sel), .lvl(level_sel), .pi(li), .pq(lq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      phase     <= '0;
      level     <= '0;
      i_out     <= '0;
      q_out     <= '0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      if (tick) begin
        if (bypass) begin
          i_out     <= clamp(ext_i);
          q_out     <= clamp(ext_q);
          smp_valid <= 1'b1;
          st        <= ST_IDLE;
          level     <= '0;
        end else begin
          case (st)
            ST_IDLE: begin
              i_out <= '0;
              q_out <= '0;
              if (burst_req) begin
                st        <= ST_UP;
                phase     <= '0;
                level     <= LVW'(1);
                smp_valid <= 1'b1;
              end
            end
            ST_UP: begin
              i_out <= li; q_out <= lq; smp_valid <= 1'b1;
              if (level == LVW'(RAMP_LEN - 1)) begin
                st    <= ST_RUN;
                level <= LVW'(RAMP_LEN);
              end else level <= level + 1'b1;
            end
            ST_RUN: begin
              i_out <= li; q_out <= lq; smp_valid <= 1'b1;
              phase <= phase_sel;
              if (!burst_req) begin
                st    <= ST_DN;
                level <= LVW'(RAMP_LEN - 2);
              end
            end
            default: begin
              i_out <= li; q_out <= lq; smp_valid <= 1'b1;
              if (level == '0) st <= ST_IDLE;
              else             level <= level - 1'b1;
            end
          endcase
        end
      end
    end
  end

  // R3: output words stay inside the calibration headroom
  a_r3_range: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> (i_out <= LIM_P && i_out >= LIM_N && q_out <= LIM_P && q_out >= LIM_N));

  // R4: a burst always opens from phase index 0
  a_r4_phase_zero: assert property (@(posedge clk) disable iff (rst)
    (st == ST_UP && $past(st) == ST_IDLE) |-> (phase == 3'd0));

  // R6: phase frozen while ramping
  a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_UP || st == ST_DN) && $past(st) == st) |-> $stable(phase));

  // R8: strobe lasts a single clock
  a_r8_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);

  // R5: idle without bypass stays silent
  a_r5_idle_silent: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && $past(st) == ST_IDLE && !$past(bypass)) |-> !smp_valid);
endmodule

// File: tb/tb_dqpsk_mapper.sv
module tb_dqpsk_mapper;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bypass = 1'b0, burst_req = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic signed [9:0] ext_i = '0, ext_q = '0;
  logic signed [9:0] i_out, q_out;
  logic smp_valid;

  int checks = 0, failures = 0;
  int ph = 0;
  int si, sq;
  bit got;

  always #2.5 clk = ~clk;

  dqpsk_mapper dut (
    .clk(clk), .rst(rst), .bypass(bypass), .burst_req(burst_req),
    .bit_valid(bit_valid), .bit_data(bit_data), .ext_i(ext_i), .ext_q(ext_q),
    .i_out(i_out), .q_out(q_out), .smp_valid(smp_valid)
  );

  function automatic int pt_i(input int k);
    case (k % 8)
      0: return 400; 1: return 283; 2: return 0; 3: return -283;
      4: return -400; 5: return -283; 6: return 0; default: return 283;
    endcase
  endfunction

  function automatic int pt_q(input int k);
    return pt_i((k + 6) % 8);
  endfunction

  function automatic int scl(input int p, input int lvl);
    return (p * lvl) >>> 3;
  endfunction

  function automatic int step_of(input bit x, input bit y);
    case ({x, y})
      2'b00: return 1; 2'b01: return 3; 2'b11: return 5; default: return 7;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_sample();
    got = 1'b0;
    for (int n = 0; n < 64 && !got; n++) begin
      @(negedge clk);
      if (smp_valid) begin
        got = 1'b1;
        si = int'(i_out);
        sq = int'(q_out);
      end
    end
    if (!got) chk("R8 sample timeout", 0, 1);
  endtask

  task automatic send_dibit(input bit x, input bit y);
    @(negedge clk); bit_valid = 1'b1; bit_data = x;
    @(negedge clk); bit_data = y;
    @(negedge clk); bit_valid = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 i_out", int'(i_out), 0);
    chk("R10 q_out", int'(q_out), 0);
    chk("R10 smp_valid", int'(smp_valid), 0);
  endtask

  task automatic t_ramp_up();
    burst_req = 1'b1;
    ph = 0;
    for (int k = 0; k < 8; k++) begin
      wait_sample();
      chk($sformatf("R4 ramp-up I level %0d", k), si, scl(400, k));
      chk($sformatf("R4 ramp-up Q level %0d", k), sq, 0);
      if (k == 2) send_dibit(1'b1, 1'b1);
    end
    wait_sample();
    chk("R6 bits during ramp ignored I", si, 400);
    chk("R6 bits during ramp ignored Q", sq, 0);
  endtask

  task automatic t_run_steps();
    bit xs[10] = '{0, 0, 0, 1, 1, 1, 0, 0, 1, 0};
    bit ys[10] = '{0, 0, 1, 1, 0, 0, 1, 1, 1, 0};
    for (int n = 0; n < 10; n++) begin
      send_dibit(xs[n], ys[n]);
      ph = (ph + step_of(xs[n], ys[n])) % 8;
      wait_sample();
      chk($sformatf("R1/R2 step %0d I", n), si, pt_i(ph));
      chk($sformatf("R1/R2 step %0d Q", n), sq, pt_q(ph));
    end
  endtask

  task automatic t_hold();
    wait_sample();
    chk("R7 hold I", si, pt_i(ph));
    chk("R7 hold Q", sq, pt_q(ph));
  endtask

  task automatic t_ramp_down();
    send_dibit(1'b0, 1'b0);
    ph = (ph + 1) % 8;
    wait_sample();
    chk("R1 pre-ramp step I", si, pt_i(ph));
    chk("R1 pre-ramp step Q", sq, pt_q(ph));
    burst_req = 1'b0;
    send_dibit(1'b0, 1'b1);
    for (int k = 7; k >= 0; k--) begin
      wait_sample();
      chk($sformatf("R5 ramp-down I level %0d", k), si, scl(pt_i(ph), k));
      chk($sformatf("R5 ramp-down Q level %0d", k), sq, scl(pt_q(ph), k));
    end
    got = 1'b0;
    for (int n = 0; n < 48; n++) begin
      @(negedge clk);
      if (smp_valid) got = 1'b1;
    end
    chk("R5 idle no strobe", int'(got), 0);
    chk("R5 idle I zero", int'(i_out), 0);
  endtask

  task automatic t_restart();
    chk("R4 prior phase non-zero", int'(ph != 0), 1);
    burst_req = 1'b1;
    wait_sample();
    chk("R4 restart level0 I", si, 0);
    wait_sample();
    chk("R4 restart phase0 I", si, 50);
    chk("R4 restart phase0 Q", sq, 0);
    burst_req = 1'b0;
    repeat (400) @(negedge clk);
  endtask

  task automatic t_bypass();
    int t0;
    bypass = 1'b1; ext_i = 10'sd100; ext_q = -10'sd200;
    wait_sample();
    chk("R9 bypass I", si, 100);
    chk("R9 bypass Q", sq, -200);
    t0 = 0;
    got = 1'b0;
    for (int n = 1; n <= 64 && !got; n++) begin
      @(negedge clk);
      if (smp_valid) begin got = 1'b1; t0 = n; end
    end
    chk("R8 sample spacing", t0, 16);
    ext_i = 10'sd500; ext_q = -10'sd512;
    wait_sample();
    chk("R3 clamp high", si, 450);
    chk("R3 clamp low", sq, -450);
    ext_i = 10'sd450; ext_q = -10'sd450;
    wait_sample();
    chk("R9 limit passes I", si, 450);
    chk("R9 limit passes Q", sq, -450);
    bypass = 1'b0;
  endtask

  initial begin
    t_reset();
    t_ramp_up();
    t_run_steps();
    t_hold();
    t_ramp_down();
    t_restart();
    t_bypass();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule